// File: doc/BRIEF.md
# UART Bit-Timing Generator with Predivider and Break Timer

This block produces the sampling cadence for a serial transmitter and receiver from a fast system clock. The clock passes through three cascaded counters. The first is a programmable predivider. The second is a programmable baud divisor. The third is a fixed count of thirteen oversampling ticks per bit. The result is a fine-grained oversampling strobe and a coarser once-per-bit strobe. Both divider settings arrive through a single packed register write. Between the predivider and the baud divisor, the predivider is meant to bring the system clock down to about 12 MHz.

A new setting is not applied at once. It is held as pending, with a busy flag raised, until the current bit period ends. Software polls the flag before it writes again, and a write made while the flag is set is dropped. This means a bit period that is already running always keeps its full length.

The block also times line breaks. Software loads a break length, counted in bit periods. A break request then forces the transmit line low for that many bit boundaries. While the break runs, the request reads back as active. When the break finishes, that readback clears and a one-cycle completion strobe fires. Software is expected to scale the break length with the baud rate, in proportion to baud × 4096 / 10^6.

Top module: `uart_baud_gen`

## Requirements
- R1: In the divisor write word, bits [9:0] carry the baud divisor minus one and bits [19:16] carry the predivider minus one; all other bits of the word have no effect on timing.
- R2: With active predivider field P and divisor field D, `os_tick` pulses once every (P+1)·(D+1) clocks and `bit_tick` pulses on every 13th `os_tick`, giving a bit period of 13·(P+1)·(D+1) clocks with exactly 13 `os_tick` pulses per period.
- R3: An accepted divisor write raises `div_busy` in the next cycle. `div_busy` stays high until the next `bit_tick` and is low in the cycle after that tick.
- R4: A divisor written while not busy governs the bit periods that follow the first `bit_tick` after the write; the period in progress keeps its old length, also when the write is sampled in the very cycle of a `bit_tick`.
- R5: A divisor write presented while `div_busy` is high is discarded and does not change the pending or active setting.
- R6: After reset both fields are zero (bit period of 13 clocks), `div_busy` is low, no break is running, `tx_break_low` is low and `brk_done` is low.
- R7: A break request while idle sets `brk_active` and `tx_break_low` in the next cycle and holds them through N `bit_tick` pulses, where N is the break length register; a length of 0 behaves as 1.
- R8: `brk_done` is high for exactly one cycle: the first cycle in which `brk_active` is low again after a break.
- R9: A break request made while a break is running is ignored and does not extend the break.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| div_wr | input | 1 | Write strobe for the packed divisor word |
| div_wdata | input | 32 | Packed divisor word (see R1) |
| div_busy | output | 1 | High while a written divisor is waiting to be applied |
| brk_len_wr | input | 1 | Write strobe for the break length |
| brk_len_wdata | input | 16 | Break length in bit periods |
| brk_req | input | 1 | Break request pulse |
| brk_active | output | 1 | Break request readback; high while a break runs |
| brk_done | output | 1 | One-cycle strobe when a break ends |
| tx_break_low | output | 1 | Forces the transmit line low while high |
| os_tick | output | 1 | Oversampling strobe |
| bit_tick | output | 1 | Once-per-bit strobe |

## Verification
Two things can happen on the same bit boundary. A pending divisor can be applied there, and the break timer, which counts the same `bit_tick`, can expire there. The bench sets this up by starting a two-bit break and then, after the break's first bit boundary, writing a new divisor. Both events then fall on the second boundary. It checks that the break still ends after exactly two boundaries, with its done strobe in the next cycle, that the busy flag is clear at that point, and that the interval after the boundary already has the new length. A second case times a divisor write so that it is sampled in the tick cycle itself. The scoreboard must then see one more interval of the old length.

// File: rtl/ubg_pkg.sv
// Package: shared constants and types for the UART bit-timing generator.
// Assumes a packed divisor word whose field positions are fixed by software.
package ubg_pkg;
    localparam int DIV_LSB = 0;   // baud divisor field low bit
    localparam int PRE_LSB = 16;  // predivider field low bit

    typedef enum logic {
        BRK_IDLE = 1'b0,
        BRK_RUN  = 1'b1
    } brk_state_e;
endpackage

// File: rtl/ubg_stage.sv
// Module: one wrap-around counter stage of the divider chain.
// It counts enable pulses from 0 up to LIMIT and emits a wrap strobe on the
// pulse where it returns to 0. It assumes LIMIT changes only while the count is 0.
module ubg_stage #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] limit,
    output logic         wrap
);
    logic [W-1:0] cnt;

    // Strobe on the enabled pulse that closes a full count.
    assign wrap = en && (cnt >= limit);

    // Advance the count on each enable and wrap to zero at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (en) begin
            cnt <= (cnt >= limit) ? '0 : cnt + 1'b1;
        end
    end
endmodule

// File: rtl/ubg_break.sv
// Module: break-duration timer.
// It holds a length in bit periods. On a request while idle it runs for that
// many bit strobes, then emits a one-cycle done strobe. Requests made while it
// runs are ignored. A length of zero runs for one bit strobe.
module ubg_break
    import ubg_pkg::*;
#(
    parameter int BRK_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             len_wr,
    input  logic [BRK_W-1:0] len_wdata,
    input  logic             req,
    input  logic             bit_tick,
    output logic             active,
    output logic             done
);
    brk_state_e       state;
    logic [BRK_W-1:0] len_q;
    logic [BRK_W-1:0] remain;

    assign active = (state == BRK_RUN);

    // Hold the programmed break length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q <= '0;
        end else if (len_wr) begin
            len_q <= len_wdata;
        end
    end

    // Run the break over the programmed number of bit strobes and flag its end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= BRK_IDLE;
            remain <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (state == BRK_IDLE) begin
                if (req) begin
                    state  <= BRK_RUN;
                    remain <= (len_q == '0) ? BRK_W'(1) : len_q;
                end
            end else if (bit_tick) begin
                if (remain <= BRK_W'(1)) begin
                    state <= BRK_IDLE;
                    done  <= 1'b1;
                end else begin
                    remain <= remain - 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/uart_baud_gen.sv
// Module: UART bit-timing generator (top).
// The chain is predivider -> baud divisor -> fixed oversampling count. A
// packed divisor write is held as pending, with busy raised, and applied at
// the next bit boundary. There every counter is at zero, so no running bit
// period is shortened. It also hosts the break timer, which counts bit strobes.
module uart_baud_gen
    import ubg_pkg::*;
#(
    parameter int DIV_W = 10,
    parameter int PRE_W = 4,
    parameter int OVS   = 13,
    parameter int REG_W = 32,
    parameter int BRK_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             div_wr,
    input  logic [REG_W-1:0] div_wdata,
    output logic             div_busy,
    input  logic             brk_len_wr,
    input  logic [BRK_W-1:0] brk_len_wdata,
    input  logic             brk_req,
    output logic             brk_active,
    output logic             brk_done,
    output logic             tx_break_low,
    output logic             os_tick,
    output logic             bit_tick
);
    localparam int OVS_W = (OVS > 1) ? $clog2(OVS) : 1;
    localparam logic [OVS_W-1:0] OVS_LIM = OVS_W'(OVS - 1);

    logic [PRE_W-1:0] pre_act, pre_pend;
    logic [DIV_W-1:0] div_act, div_pend;
    logic             busy_q;
    logic             pre_en;

    assign div_busy = busy_q;

    // Capture a write while idle, and apply the pending value at a bit boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_act  <= '0;
            div_act  <= '0;
            pre_pend <= '0;
            div_pend <= '0;
            busy_q   <= 1'b0;
        end else if (busy_q) begin
            if (bit_tick) begin
                pre_act <= pre_pend;
                div_act <= div_pend;
                busy_q  <= 1'b0;
            end
        end else if (div_wr) begin
            pre_pend <= div_wdata[PRE_LSB +: PRE_W];
            div_pend <= div_wdata[DIV_LSB +: DIV_W];
            busy_q   <= 1'b1;
        end
    end

    ubg_stage #(.W(PRE_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .en(1'b1), .limit(pre_act), .wrap(pre_en)
    );

    ubg_stage #(.W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .en(pre_en), .limit(div_act), .wrap(os_tick)
    );

    ubg_stage #(.W(OVS_W)) u_ovs (
        .clk(clk), .rst_n(rst_n), .en(os_tick), .limit(OVS_LIM), .wrap(bit_tick)
    );

    ubg_break #(.BRK_W(BRK_W)) u_brk (
        .clk(clk), .rst_n(rst_n),
        .len_wr(brk_len_wr), .len_wdata(brk_len_wdata),
        .req(brk_req), .bit_tick(bit_tick),
        .active(brk_active), .done(brk_done)
    );

    // Drive the transmit line low for the whole break.
    assign tx_break_low = brk_active;
endmodule

// File: rtl/ubg_checker.sv
// Module: property checker for uart_baud_gen, attached with bind below.
// It observes only the ports of the top module.
module ubg_checker (
    input logic clk,
    input logic rst_n,
    input logic div_wr,
    input logic div_busy,
    input logic brk_req,
    input logic brk_active,
    input logic brk_done,
    input logic tx_break_low,
    input logic os_tick,
    input logic bit_tick
);
    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |=> (!div_busy && !brk_active && !brk_done)); // R6

    AST_BUSY_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (!div_busy && div_wr) |=> div_busy); // R3

    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (div_busy && !bit_tick) |=> div_busy); // R5

    AST_BUSY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (div_busy && bit_tick) |=> !div_busy); // R3

    AST_BIT_ON_OS: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |-> os_tick); // R2

    AST_BREAK_START: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_req && !brk_active) |=> (brk_active && tx_break_low)); // R7

    AST_BREAK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_active && !bit_tick) |=> brk_active); // R9

    AST_DONE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        brk_done |-> (!brk_active && $past(brk_active))); // R8

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        brk_done |=> !brk_done); // R8
endmodule

bind uart_baud_gen ubg_checker u_chk (
    .clk(clk), .rst_n(rst_n), .div_wr(div_wr), .div_busy(div_busy),
    .brk_req(brk_req), .brk_active(brk_active), .brk_done(brk_done),
    .tx_break_low(tx_break_low), .os_tick(os_tick), .bit_tick(bit_tick)
);

// File: tb/sim_uart_baud_gen.sv
// Bench: a scoreboard for uart_baud_gen. The driver pushes expected bit-period
// lengths into a queue. The monitor measures each period between bit strobes
// and pops and compares.
module sim_uart_baud_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        div_wr = 1'b0;
    logic [31:0] div_wdata = '0;
    logic        div_busy;
    logic        brk_len_wr = 1'b0;
    logic [15:0] brk_len_wdata = '0;
    logic        brk_req = 1'b0;
    logic        brk_active, brk_done, tx_break_low, os_tick, bit_tick;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int last_tick = 0;
    bit have_last = 1'b0;
    int os_count = 0;
    int exp_q[$];
    string tag_q[$];

    uart_baud_gen u0 (
        .clk(clk), .rst_n(rst_n), .div_wr(div_wr), .div_wdata(div_wdata),
        .div_busy(div_busy), .brk_len_wr(brk_len_wr), .brk_len_wdata(brk_len_wdata),
        .brk_req(brk_req), .brk_active(brk_active), .brk_done(brk_done),
        .tx_break_low(tx_break_low), .os_tick(os_tick), .bit_tick(bit_tick)
    );

    always #4 clk = ~clk;  // 125 MHz

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Monitor: measure each bit period and its oversampling count against the queue.
    always @(negedge clk) begin
        if (!rst_n) begin
            have_last = 1'b0;
            os_count = 0;
        end else begin
            if (os_tick) os_count++;
            if (bit_tick) begin
                if (have_last && exp_q.size() > 0) begin
                    int e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk((cyc - last_tick) == e, t, cyc - last_tick, e);
                    chk(os_count == 13, "R2 os per bit", os_count, 13);
                end
                last_tick = cyc;
                have_last = 1'b1;
                os_count = 0;
            end
        end
    end

    task automatic push(input int e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
    endtask

    task automatic sync_tick();
        do @(negedge clk); while (!bit_tick);
        @(posedge clk);
    endtask

    task automatic drain();
        while (exp_q.size() > 0) @(negedge clk);
    endtask

    task automatic wr_div(input logic [31:0] v);
        @(negedge clk);
        div_wr = 1'b1;
        div_wdata = v;
        @(negedge clk);
        div_wr = 1'b0;
    endtask

    task automatic set_brk_len(input logic [15:0] v);
        @(negedge clk);
        brk_len_wr = 1'b1;
        brk_len_wdata = v;
        @(negedge clk);
        brk_len_wr = 1'b0;
    endtask

    // Run one break; optionally poke a second request mid-break and count strobes.
    task automatic run_break(input int exp_n, input bit poke, input string req);
        int n = 0;
        bit poked = 1'b0;
        @(negedge clk);
        brk_req = 1'b1;
        @(negedge clk);
        brk_req = 1'b0;
        chk(brk_active && tx_break_low, "R7 start", int'(brk_active), 1);
        while (brk_active) begin
            if (bit_tick) n++;
            if (poke && n == 1 && !poked) begin
                brk_req = 1'b1;
                poked = 1'b1;
            end else begin
                brk_req = 1'b0;
            end
            @(negedge clk);
        end
        brk_req = 1'b0;
        chk(n == exp_n, req, n, exp_n);
        chk(brk_done == 1'b1, "R8 done on fall", int'(brk_done), 1);
        chk(tx_break_low == 1'b0, "R7 line released", int'(tx_break_low), 0);
        @(negedge clk);
        chk(brk_done == 1'b0, "R8 done single", int'(brk_done), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R6 reset state
        chk(!div_busy, "R6 busy", int'(div_busy), 0);
        chk(!brk_active && !tx_break_low, "R6 break idle", int'(brk_active), 0);
        chk(!brk_done, "R6 done", int'(brk_done), 0);

        // R6/R2 default period 13
        sync_tick();
        push(13, "R6 default period");
        push(13, "R2 period P0 D0");
        drain();

        // R3/R4 divisor 2 -> 39, running period untouched
        sync_tick();
        push(13, "R4 old period kept");
        push(39, "R2 period D2");
        repeat (2) @(negedge clk);
        wr_div(32'd2);
        chk(div_busy, "R3 busy after write", int'(div_busy), 1);
        drain();
        chk(!div_busy, "R3 busy cleared", int'(div_busy), 0);

        // R1/R5 fields with junk bits, second write while busy dropped
        sync_tick();
        push(39, "R4 old period kept");
        push(52, "R1 fields P1 D1");
        push(52, "R5 busy write ignored");
        wr_div(32'hFFF1_FC01);
        wr_div(32'd5);
        chk(div_busy, "R5 still busy", int'(div_busy), 1);
        drain();

        // R4 write sampled in the tick cycle itself
        do @(negedge clk); while (!bit_tick);
        div_wr = 1'b1;
        div_wdata = 32'd0;
        @(posedge clk);
        push(52, "R4 boundary write keeps period");
        push(13, "R4 boundary write applies next");
        @(negedge clk);
        div_wr = 1'b0;
        chk(div_busy, "R3 busy boundary write", int'(div_busy), 1);
        drain();

        // R7/R8 break of 3, R9 extra request ignored, length 0 as 1
        set_brk_len(16'd3);
        run_break(3, 1'b0, "R7 length 3");
        set_brk_len(16'd4);
        run_break(4, 1'b1, "R9 request during break");
        set_brk_len(16'd0);
        run_break(1, 1'b0, "R7 length 0");

        // Same boundary: break of 2 ends where divisor 1 is applied
        set_brk_len(16'd2);
        @(negedge clk);
        brk_req = 1'b1;
        @(negedge clk);
        brk_req = 1'b0;
        do @(negedge clk); while (!bit_tick);
        chk(brk_active, "R7 still running", int'(brk_active), 1);
        @(posedge clk);
        push(13, "R4 period before collision");
        push(26, "R4 period after collision");
        wr_div(32'd1);
        begin
            int n = 0;
            while (brk_active) begin
                if (bit_tick) n++;
                @(negedge clk);
            end
            chk(n == 1, "R7 collision count", n + 1, 2);
        end
        chk(brk_done, "R8 done at collision", int'(brk_done), 1);
        chk(!div_busy, "R3 applied at collision", int'(div_busy), 0);
        drain();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule